// File: doc/BRIEF.md
# Chopped Bang-Bang Loop Filter

This block is the digital integrator of a frequency-locked oscillator loop. Once per loop cycle it takes one comparator decision that says whether the oscillator runs slow or fast. The comparator input is chopped, so the block first undoes the chopping by flipping the decision in one chop phase. It then adds or subtracts a step of two to the power of a shift setting in an 18-bit accumulator that saturates instead of wrapping.

The top 11 accumulator bits are the frequency control word. Its upper 8 bits become a 255-wide thermometer code for a unary DAC. Its lower 3 bits go to a sigma-delta modulator as the fractional part. The block also drives the chop phase to the analog chopper, so the inversion and the analog swap always share one state. A load input presets the accumulator to a trim value at start-up. In lock, the control word toggles between two adjacent codes.

Top module: `bb_loop_filter`

## Requirements
- R1: After reset the accumulator is 0x20000 (control word 0x400, integer field 128, fraction 0) and the chop phase is 0.
- R2: The chop phase output toggles after every second accepted update (an update strobe without load), and changes at no other time.
- R3: On an accepted update, the corrected decision is the decision bit XOR the chop phase in use at that update. A corrected value of 1 (oscillator too slow) raises the accumulator and 0 lowers it.
- R4: The step added or subtracted is 2 to the power of the shift input (0 to 15).
- R5: A raise that would pass 0x3FFFF leaves the accumulator at 0x3FFFF.
- R6: A lowering that would go below 0 leaves the accumulator at 0.
- R7: When load is high, the accumulator takes the load value on that edge, and a simultaneous update strobe is ignored, including for the chop phase.
- R8: With neither strobe nor load, the accumulator and chop phase hold whatever the decision and shift inputs do.
- R9: The control word is accumulator bits 17..7. Its bits 10..3 are the integer field and bits 2..0 are the fraction output.
- R10: Thermometer bit i is 1 exactly when the integer field is greater than i, for i from 0 to 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd | input | 1 | One-cycle strobe per loop update |
| dec | input | 1 | Raw comparator decision |
| shift | input | 4 | Gain setting: step is 2^shift |
| load | input | 1 | Preset strobe |
| load_val | input | 18 | Preset value for the accumulator |
| chop | output | 1 | Chop phase to the analog chopper |
| fcw | output | 11 | Frequency control word |
| therm | output | 255 | Unary code of the integer field |
| frac | output | 3 | Fractional field to the modulator |

## Verification
Every result is registered once. The accumulator, the control word, its thermometer and fraction fields, and the chop phase all show the effect of a strobe on the clock edge that samples it. The outputs are combinational from those registers. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares shortly after that edge against a model updated for exactly that edge. The model picks the chop phase used by an update from its own value before that update advances it.

// File: rtl/bb_loop_filter.sv
module bb_loop_filter #(
  parameter int ACC_W    = 18,
  parameter int FCW_W    = 11,
  parameter int FRAC_W   = 3,
  parameter int SHIFT_W  = 4,
  parameter int CHOP_UPD = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              upd,
  input  logic                              dec,
  input  logic [SHIFT_W-1:0]                shift,
  input  logic                              load,
  input  logic [ACC_W-1:0]                  load_val,
  output logic                              chop,
  output logic [FCW_W-1:0]                  fcw,
  output logic [(1<<(FCW_W-FRAC_W))-2:0]    therm,
  output logic [FRAC_W-1:0]                 frac
);
  localparam int INT_W = FCW_W - FRAC_W;
  localparam int UNITS = (1 << INT_W) - 1;
  localparam int CNT_W = (CHOP_UPD > 1) ? $clog2(CHOP_UPD) : 1;
  localparam logic [ACC_W-1:0] MID = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] acc, acc_nx;
  logic [CNT_W-1:0] cnt;
  logic             take;
  logic             raise;
  logic [ACC_W:0]   step, sum, dif;

  assign take  = upd & ~load;
  assign raise = dec ^ chop;
  assign step  = {{ACC_W{1'b0}}, 1'b1} << shift;
  assign sum   = {1'b0, acc} + step;
  assign dif   = {1'b0, acc} - step;

  always_comb begin
    if (raise) acc_nx = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    else       acc_nx = dif[ACC_W] ? {ACC_W{1'b0}} : dif[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= MID;
    else if (load)   acc <= load_val;
    else if (upd)    acc <= acc_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      chop <= 1'b0;
    end else if (take) begin
      if (cnt == CNT_W'(CHOP_UPD - 1)) begin
        cnt  <= '0;
        chop <= ~chop;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end
  end

  assign fcw  = acc[ACC_W-1 -: FCW_W];
  assign frac = fcw[FRAC_W-1:0];

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    assign therm[i] = fcw[FCW_W-1:FRAC_W] > INT_W'(i);
  end
endmodule

// File: rtl/bb_loop_filter_chk.sv
module bb_loop_filter_chk #(
  parameter int ACC_W  = 18,
  parameter int FCW_W  = 11,
  parameter int FRAC_W = 3,
  parameter int UNITS  = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd,
  input logic             dec,
  input logic             load,
  input logic [ACC_W-1:0] load_val,
  input logic             chop,
  input logic [ACC_W-1:0] acc,
  input logic [FCW_W-1:0] fcw,
  input logic [UNITS-1:0] therm
);
  // R3 R5
  up_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !load && (dec ^ chop)) |=> acc >= $past(acc));

  // R3 R6
  down_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !load && !(dec ^ chop)) |=> acc <= $past(acc));

  // R7
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> acc == $past(load_val));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !load) |=> ($stable(acc) && $stable(chop)));

  // R2
  chop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd || load) |=> $stable(chop));

  // R10
  therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm) == int'(fcw[FCW_W-1:FRAC_W]));
endmodule

bind bb_loop_filter bb_loop_filter_chk #(
  .ACC_W(ACC_W), .FCW_W(FCW_W), .FRAC_W(FRAC_W), .UNITS(UNITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .dec(dec), .load(load),
  .load_val(load_val), .chop(chop), .acc(acc), .fcw(fcw), .therm(therm)
);

// File: tb/test_bb_loop_filter.sv
`timescale 1ns/1ps
module test_bb_loop_filter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         upd = 1'b0, dec = 1'b0, load = 1'b0;
  logic [3:0]   shift = '0;
  logic [17:0]  load_val = '0;
  logic         chop;
  logic [10:0]  fcw;
  logic [254:0] therm;
  logic [2:0]   frac;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [17:0] m_acc;
  logic        m_chop;
  int          m_cnt;

  always #4 clk = ~clk;

  bb_loop_filter i_bb_loop_filter (
    .clk(clk), .rst_n(rst_n), .upd(upd), .dec(dec), .shift(shift),
    .load(load), .load_val(load_val), .chop(chop), .fcw(fcw),
    .therm(therm), .frac(frac)
  );

  task automatic cmp(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [7:0] ef;
    logic [254:0] et;
    ef = m_acc[17:10];
    for (int i = 0; i < 255; i++) et[i] = (ef > i);
    cmp({req, " fcw"}, int'(fcw), int'(m_acc[17:7]));
    cmp({req, " frac"}, int'(frac), int'(m_acc[9:7]));
    cmp({req, " chop"}, int'(chop), int'(m_chop));
    n_cmp++;
    if (therm !== et) begin
      n_bad++;
      $display("FAIL %s therm: actual ones %0d expected ones %0d", req,
               $countones(therm), $countones(et));
    end
  endtask

  task automatic cyc(input logic u, input logic d, input logic l,
                     input logic [17:0] v, input logic [3:0] s, input string req);
    logic [18:0] t;
    @(negedge clk);
    upd = u; dec = d; load = l; load_val = v; shift = s;
    @(posedge clk);
    #2;
    if (l) m_acc = v;
    else if (u) begin
      if (d ^ m_chop) begin
        t = {1'b0, m_acc} + (19'd1 << s);
        m_acc = t[18] ? 18'h3FFFF : t[17:0];
      end else begin
        t = {1'b0, m_acc} - (19'd1 << s);
        m_acc = t[18] ? 18'h0 : t[17:0];
      end
      m_cnt++;
      if (m_cnt == 2) begin m_cnt = 0; m_chop = ~m_chop; end
    end
    check_all(req);
    upd = 0; load = 0;
  endtask

  initial begin
    m_acc = 18'h20000; m_chop = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    cmp("R1 fcw", int'(fcw), 32'h400);

    // R3 R4: every shift, mixed decisions
    for (int s = 0; s < 16; s++) begin
      cyc(0, 0, 1, 18'h20000, 4'(s), "R7 preset");
      for (int k = 0; k < 8; k++)
        cyc(1, 1'((k ^ s) & 1) ^ 1'(k >> 2), 0, '0, 4'(s), "R3/R4 step");
    end

    // R2: constant raw decision, chop phase alternates every two updates
    for (int k = 0; k < 12; k++) cyc(1, 0, 0, '0, 4'd7, "R2 chop");

    // R5: push to the top
    cyc(0, 0, 1, 18'h3FFFA, 4'd4, "R7 preset");
    for (int k = 0; k < 6; k++) cyc(1, ~m_chop, 0, '0, 4'd4, "R5 top");
    cmp("R5 pinned", int'(fcw), 32'h7FF);

    // R6: push to the bottom
    cyc(0, 0, 1, 18'h00003, 4'd2, "R7 preset");
    for (int k = 0; k < 6; k++) cyc(1, m_chop, 0, '0, 4'd15, "R6 bottom");
    cmp("R6 pinned", int'(fcw), 0);

    // R7: load wins over update, chop does not advance
    cyc(1, 1, 0, '0, 4'd0, "R7 pre");
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 18'h1_2480 + 18'(k), 4'd9, "R7 load+upd");

    // R8: idle with busy inputs
    for (int k = 0; k < 10; k++) cyc(0, 1'(k), 0, 18'h3FFFF, 4'(k), "R8 idle");

    // R9 R10: every integer field value with varied fraction
    for (int k = 0; k < 256; k++)
      cyc(0, 0, 1, (18'(k) << 10) | (18'(k % 8) << 7) | 18'(k % 128), 4'd0, "R9/R10 field");

    // lock toggling at a fine step
    cyc(0, 0, 1, 18'h20040, 4'd7, "R7 preset");
    for (int k = 0; k < 16; k++) cyc(1, 1'(k) ^ m_chop, 0, '0, 4'd7, "R3 lock");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule